// File: doc/BRIEF.md
# Adder-Based Selectable Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It produces a W-bit result and a carry flag from two W-bit operands and a 4-bit function code. All eight arithmetic functions come from a single ripple-carry adder. Only the adder's conditioned operand and its carry-in change from one function to the next. The second adder operand is always X.

A bitwise logic path runs in parallel with the arithmetic path. Both paths compute on every input change. The top bit of the function code steers an output multiplexer that picks one of the two results.

The carry flag reports the adder's most significant carry only while an arithmetic function is selected. For every logic function the carry flag is held at zero.

Top module: `sel_alu`

## Requirements
- R1: When func_sel[3]=0, result equals (X + P + func_sel[0]) mod 2^W. X is opnd_x, and the carry-in is func_sel[0].
- R2: The conditioned operand P is selected by func_sel[2:1]: 00 gives all zeros, 01 gives opnd_y, 10 gives the bitwise complement of opnd_y, and 11 gives all ones.
- R3: Arithmetic codes func_sel=0000 and func_sel=0111 both return opnd_x unchanged. Code 0000 gives carry_out=0 and code 0111 gives carry_out=1.
- R4: Code 0001 returns X+1 and code 0110 returns X-1, both modulo 2^W.
- R5: Code 0101 returns X-Y in two's complement, with carry_out=1 exactly when X>=Y (unsigned). Code 0100 returns X+~Y.
- R6: For codes with func_sel[3]=0, carry_out equals bit W of the (W+1)-bit sum X + P + func_sel[0].
- R7: When func_sel[3]=1, func_sel[1:0] selects the bitwise function: 00 gives X AND Y, 01 gives X OR Y, 10 gives X XOR Y, and 11 gives NOT X. The value of func_sel[2] has no effect on the result.
- R8: func_sel[3] alone chooses the source of result: 0 selects the arithmetic path and 1 selects the logic path.
- R9: When func_sel[3]=1, carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | W | First operand; always feeds the adder directly |
| opnd_y | input | W | Second operand; conditioned before it reaches the adder |
| func_sel | input | 4 | Function code: bit 3 picks the path, bits 2..0 pick the function |
| result | output | W | Selected result |
| carry_out | output | 1 | Adder carry for arithmetic codes, 0 for logic codes |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same evaluation as the input that exposes it. Operand conditioning with the wrong polarity would appear as a wrong result only for the function codes that use that setting of the select bits. A break in the ripple chain would corrupt the upper result bits and the carry only for operand pairs that propagate a carry through the broken position. The bench therefore applies all 16 codes to every operand pair, so that every carry pattern reaches the outputs.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

    // Bitwise functions of the logic path, indexed by func_sel[1:0]
    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTX = 2'b11
    } logic_op_e;

    // Decoded control fields carried from the function code into the datapath
    typedef struct packed {
        logic      use_logic;   // choose the logic path at the output
        logic      want_inv_y;  // conditioned operand includes the complement of Y
        logic      want_y;      // conditioned operand includes Y
        logic      carry_in;    // adder carry-in
        logic_op_e lop;         // bitwise function
    } func_ctl_t;

    localparam int unsigned SEL_W = 4;

    function automatic func_ctl_t decode_sel(input logic [SEL_W-1:0] sel);
        func_ctl_t c;
        c.use_logic  = sel[3];
        c.want_inv_y = sel[2];
        c.want_y     = sel[1];
        c.carry_in   = sel[0];
        c.lop        = logic_op_e'(sel[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/sel_alu_opnd_cond.sv
module sel_alu_opnd_cond #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] y_in,
    input  logic         inv_en,
    input  logic         pass_en,
    output logic [W-1:0] p_out
);
    // Per bit: (inv_en & ~y) | (pass_en & y)
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign p_out[i] = (inv_en & ~y_in[i]) | (pass_en & y_in[i]);
    end

    always_comb begin
        if (!inv_en && !pass_en)
            assert_opnd_zero_R2: assert (p_out == '0);
        if (inv_en && pass_en)
            assert_opnd_ones_R2: assert (p_out == '1);
    end
endmodule

// File: rtl/sel_alu_ripple_add.sv
module sel_alu_ripple_add #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         c_out
);
    localparam int unsigned CW = W + 1;

    logic [CW-1:0] chain;
    assign chain[0] = c_in;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic gen_b, prop_b;
        assign prop_b     = a_in[i] ^ b_in[i];
        assign gen_b      = a_in[i] & b_in[i];
        assign s_out[i]   = prop_b ^ chain[i];
        assign chain[i+1] = gen_b | (prop_b & chain[i]);
    end

    assign c_out = chain[W];

    always_comb begin
        assert_adder_sum_R1: assert ({c_out, s_out} ==
            ({1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in}));
    end
endmodule

// File: rtl/sel_alu_logic.sv
module sel_alu_logic
    import sel_alu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic_op_e    op,
    output logic [W-1:0] g_out
);
    always_comb begin
        unique case (op)
            LOP_AND:  g_out = x_in & y_in;
            LOP_OR:   g_out = x_in | y_in;
            LOP_XOR:  g_out = x_in ^ y_in;
            LOP_NOTX: g_out = ~x_in;
            default:  g_out = '0;
        endcase
    end

    always_comb begin
        if (op == LOP_NOTX)
            assert_not_ignores_y_R7: assert ((g_out ^ x_in) == '1);
    end
endmodule

// File: rtl/sel_alu.sv
module sel_alu
    import sel_alu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]     opnd_x,
    input  logic [W-1:0]     opnd_y,
    input  logic [SEL_W-1:0] func_sel,
    output logic [W-1:0]     result,
    output logic             carry_out
);
    func_ctl_t    ctl;
    logic [W-1:0] cond_p;
    logic [W-1:0] arith_g;
    logic         arith_c;
    logic [W-1:0] logic_g;

    assign ctl = decode_sel(func_sel);

    sel_alu_opnd_cond #(.W(W)) u_cond (
        .y_in    (opnd_y),
        .inv_en  (ctl.want_inv_y),
        .pass_en (ctl.want_y),
        .p_out   (cond_p)
    );

    sel_alu_ripple_add #(.W(W)) u_add (
        .a_in  (cond_p),
        .b_in  (opnd_x),
        .c_in  (ctl.carry_in),
        .s_out (arith_g),
        .c_out (arith_c)
    );

    sel_alu_logic #(.W(W)) u_logic (
        .x_in  (opnd_x),
        .y_in  (opnd_y),
        .op    (ctl.lop),
        .g_out (logic_g)
    );

    // Output multiplexer; carry is only meaningful on the arithmetic path
    assign result    = ctl.use_logic ? logic_g : arith_g;
    assign carry_out = ctl.use_logic ? 1'b0 : arith_c;

    always_comb begin
        if (func_sel[3])
            assert_logic_carry_zero_R9: assert (carry_out == 1'b0);
        if (func_sel == 4'b0000 || func_sel == 4'b0111)
            assert_transfer_R3: assert (result == opnd_x);
        if (func_sel == 4'b0000)
            assert_transfer_no_carry_R6: assert (carry_out == 1'b0);
        if (func_sel == 4'b0111)
            assert_transfer_carry_R6: assert (carry_out == 1'b1);
    end
endmodule

// File: tb/sel_alu_test.sv
module sel_alu_test;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x, y;
    logic [3:0]   s;
    logic [W-1:0] g;
    logic         co;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    sel_alu #(.W(W)) uut (
        .opnd_x(x), .opnd_y(y), .func_sel(s), .result(g), .carry_out(co)
    );

    // Behavioural reference: integer arithmetic per function code
    function automatic void model(input int xi, input int yi, input int si,
                                  output int gi, output int ci);
        int full;
        if (si >= 8) begin
            case (si & 3)
                0: gi = xi & yi;
                1: gi = xi | yi;
                2: gi = xi ^ yi;
                default: gi = (~xi) & (M - 1);
            endcase
            ci = 0;
        end else begin
            case (si)
                0: full = xi;
                1: full = xi + 1;
                2: full = xi + yi;
                3: full = xi + yi + 1;
                4: full = xi + (M - 1 - yi);
                5: full = xi + (M - 1 - yi) + 1;
                6: full = xi + (M - 1);
                default: full = xi + (M - 1) + 1;
            endcase
            gi = full % M;
            ci = full / M;
        end
    endfunction

    function automatic string req_of(input int si);
        case (si)
            0, 7: return "R3";
            1, 6: return "R4";
            4, 5: return "R5";
            2, 3: return "R1";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: x=%0d y=%0d s=%0d actual=%0d expected=%0d",
                     req, x, y, s, act, exp);
        end
    endtask

    task automatic apply(input int xi, input int yi, input int si);
        @(posedge clk);
        #1;
        x = xi[W-1:0];
        y = yi[W-1:0];
        s = si[3:0];
        @(negedge clk);
    endtask

    initial begin
        int eg, ec;
        x = '0; y = '0; s = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset-state check: all-zero inputs give a zero transfer with no carry (R3)
        @(negedge clk);
        check("R3", g, 0);
        check("R6", co, 0);

        // Directed corners
        apply(5, 9, 5);   check("R5", g, (5 - 9) & (M - 1)); check("R5", co, 0);
        apply(9, 9, 5);   check("R5", g, 0);                 check("R5", co, 1);
        apply(0, 3, 6);   check("R4", g, M - 1);             check("R6", co, 0);
        apply(M-1, 0, 1); check("R4", g, 0);                 check("R6", co, 1);
        apply(11, 14, 8); check("R7", g, 11 & 14);           check("R9", co, 0);
        apply(11, 14, 12);check("R7", g, 11 & 14);           // R7: S2 set, same result
        apply(11, 0, 11); check("R8", g, 4);                 check("R9", co, 0);
        apply(6, 3, 2);   check("R2", g, 9);
        apply(6, 3, 4);   check("R2", g, (6 + 12) % M);      check("R6", co, 1);

        // Exhaustive sweep over every code and operand pair
        for (int si = 0; si < 16; si++)
            for (int xi = 0; xi < M; xi++)
                for (int yi = 0; yi < M; yi++) begin
                    apply(xi, yi, si);
                    model(xi, yi, si, eg, ec);
                    check(req_of(si), g, eg);
                    check(si >= 8 ? "R9" : "R6", co, ec);
                end
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        #2;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule